// File: doc/BRIEF.md
# Paired-write cipher key cache

This block holds the per-station cipher keys for a wireless MAC receive and transmit path. Software loads each entry through a 32-bit register write port and can inspect it through a 32-bit read port. Internally every entry is four 64-bit words. A 32-bit write to the even half of a word is parked in a holding register, and the 64-bit word changes only when the matching odd half is written. A torn pair therefore never becomes visible to the lookup logic.

The frame path presents a 48-bit transmitter address and a unicast/group flag. One clock later the block returns whether an entry matched, which entry it was, its key type and the assembled 128-bit key. When integrity checking is enabled and the matched entry holds the temporal-key type, the block also returns the companion integrity key, which is stored a fixed 64 entries above the matched entry. A separate clear command wipes an entry, and it also wipes the key words of that entry's companion when the companion is in use.

Top module: `kc_key_cache`

## Requirements
- R1: A write to an even word index (wr_addr[0]=0) changes nothing readable. The 64-bit word {odd, even} is stored only when the odd word of the same pair (same entry, same wr_addr[2:1]) is written next. Before that, a read of either half returns the old value.
- R2: A held even half is dropped when a write to a different pair arrives before its odd half. A later odd write to the first pair then stores nothing. An odd write with no matching held even half stores nothing.
- R3: wr_addr/rd_addr = {entry[7:0], word[2:0]}. Words 0 to 7 are KEY0, KEY1, KEY2, KEY3, KEY4, TYPE, ADDR_LO and ADDR_HI. KEY1, KEY3 and ADDR_HI keep bits 15:0 and TYPE keeps bits 2:0, so a read returns zeros above those bits. Type codes are 0 clear, 1 WEP-40, 2 WEP-104, 3 WEP-128, 4 TKIP, 5 AES-OCB and 6 AES-CCM.
- R4: ADDR_LO holds address bits 32:1, ADDR_HI[14:0] holds bits 47:33, and ADDR_HI[15] is the unicast flag. A lookup with lk_group=0 matches only entries whose flag is 1 and whose stored bits equal lk_addr[47:1]. lk_addr[0] is ignored.
- R5: A lookup with lk_group=1 matches only entries whose flag is 0, whose type is not clear and whose stored bits equal lk_addr[47:1].
- R6: When several entries match, the lowest index is reported. When no entry matches, lk_hit, lk_idx, lk_type, lk_key, lk_mic_ok and lk_mic are all 0.
- R7: lk_done is 1 exactly one clock after a cycle with lk_valid=1. The result reflects the table as it stood in the request cycle.
- R8: lk_key = {KEY4, KEY3[15:0], KEY2, KEY1[15:0], KEY0}. For types 1 and 2 the KEY4 field is replaced by {24'b0, KEY4[7:0]}.
- R9: When the match has type 4, mic_en=1 in the request cycle and index+64 is less than the depth, lk_mic_ok=1 and lk_mic is entry index+64 packed as in R8 without KEY4 masking. Otherwise lk_mic_ok=0 and lk_mic=0.
- R10: A clear of an entry zeroes all eight words, so the type becomes clear. If the entry held type 4 and mic_en=1 while the clear is issued, KEY0 to KEY3 of entry index+64 are also zeroed, and that entry's KEY4, TYPE and address words are left as they were.
- R11: Writes and clears to an entry index at or beyond the depth (128) change nothing, and reads to such an index return 0.
- R12: After reset every stored word reads 0, nothing is held, and all lookup outputs and rd_data are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 11 | Write address {entry, word} |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 11 | Read address {entry, word} |
| rd_data | output | 32 | Read data, valid the clock after rd_en |
| clr_en | input | 1 | Clear-entry strobe |
| clr_idx | input | 8 | Entry to clear |
| mic_en | input | 1 | Integrity-key companion handling enabled |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 48 | Transmitter address to match |
| lk_group | input | 1 | 1 for a group-addressed frame |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | An entry matched |
| lk_idx | output | 7 | Matched entry index |
| lk_type | output | 3 | Matched key type |
| lk_key | output | 128 | Assembled key |
| lk_mic_ok | output | 1 | Companion integrity key present |
| lk_mic | output | 128 | Companion integrity key |

## Verification
The bench sweeps every entry and every word, then reads each word back and clears it. A wrong field mask shows up as stray high bits, and a wrong address split shows up as aliasing between entries or out-of-range indices. It checks that a lone even write stays invisible, and that a different pair interleaved before the odd half causes the odd write to be dropped. A design that commits on the even half, or that keeps the stale half, stores data that no full pair ever supplied. Lookup checks cover both ends of the match rules. One test flips address bit 0, which must not matter, and another flips bit 1, which must. One test sets up a lowest-index conflict. The unicast and group flag rules are tested in both directions, including a group lookup against a cleared-type entry. Companion handling is tested at the top of the range where index+64 overflows, with mic_en low, and through a clear that must touch only four words of the companion.

// File: rtl/kc_pkg.sv
package kc_pkg;

    typedef enum logic [2:0] {
        KT_CLEAR  = 3'd0,
        KT_WEP40  = 3'd1,
        KT_WEP104 = 3'd2,
        KT_WEP128 = 3'd3,
        KT_TKIP   = 3'd4,
        KT_OCB    = 3'd5,
        KT_CCM    = 3'd6
    } ktype_e;

    localparam int PAIRS_PER_ENTRY = 4;
    localparam int TYPE_PAIR       = 2;
    localparam int ADDR_PAIR       = 3;

    // Significant bits of each 32-bit word slot within an entry.
    function automatic logic [31:0] word_mask(input logic [2:0] w);
        case (w)
            3'd1, 3'd3, 3'd7: word_mask = 32'h0000_FFFF;
            3'd5:             word_mask = 32'h0000_0007;
            default:          word_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic is_short_key(input logic [2:0] t);
        is_short_key = (t == KT_WEP40) || (t == KT_WEP104);
    endfunction

    // Assemble the 128-bit key from the first two pairs and the KEY4 word.
    function automatic logic [127:0] pack_key(input logic [47:0] p0,
                                              input logic [47:0] p1,
                                              input logic [31:0] k4,
                                              input logic        short_key);
        logic [31:0] top;
        top = short_key ? {24'h0, k4[7:0]} : k4;
        pack_key = {top, p1[47:32], p1[31:0], p0[47:32], p0[31:0]};
    endfunction

endpackage

// File: rtl/kc_pair_writer.sv
module kc_pair_writer
    import kc_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [$clog2(DEPTH)+3:0]   wr_addr,
    input  logic [31:0]                wr_data,
    output logic                       cm_valid,
    output logic [$clog2(DEPTH)+1:0]   cm_slot,
    output logic [63:0]                cm_data
);
    localparam int LIDX_W = $clog2(DEPTH);
    localparam int IDX_W  = LIDX_W + 1;
    localparam int ADDR_W = IDX_W + 3;
    localparam int SLOT_W = LIDX_W + 2;

    logic [IDX_W-1:0]  wr_idx;
    logic [SLOT_W-1:0] wr_slot;
    logic              wr_in;
    logic [31:0]       wr_masked;

    logic              pend_valid;
    logic [SLOT_W-1:0] pend_slot;
    logic [31:0]       pend_lo;

    assign wr_idx    = wr_addr[ADDR_W-1:3];
    assign wr_slot   = wr_addr[SLOT_W:1];
    assign wr_in     = wr_en && (wr_idx < IDX_W'(DEPTH));
    assign wr_masked = wr_data & word_mask(wr_addr[2:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_slot  <= '0;
            pend_lo    <= '0;
        end else if (wr_in) begin
            if (!wr_addr[0]) begin
                pend_valid <= 1'b1;
                pend_slot  <= wr_slot;
                pend_lo    <= wr_masked;
            end else begin
                pend_valid <= 1'b0;
            end
        end
    end

    assign cm_valid = wr_in && wr_addr[0] && pend_valid && (pend_slot == wr_slot);
    assign cm_slot  = wr_slot;
    assign cm_data  = {wr_masked, pend_lo};

    // R1: the holding register is consumed by the odd half
    assert_hold_consumed_R1: assert property (@(posedge clk) disable iff (rst)
        cm_valid |=> !pend_valid);

    // R2: an in-range even write always leaves a half held
    assert_even_held_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_in && !wr_addr[0]) |=> pend_valid);

endmodule

// File: rtl/kc_match.sv
module kc_match
    import kc_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic [47:0]              mac_vec  [DEPTH],
    input  logic [2:0]               type_vec [DEPTH],
    input  logic [46:0]              addr_hi,
    input  logic                     group,
    output logic                     hit,
    output logic [$clog2(DEPTH)-1:0] idx
);
    localparam int LIDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic addr_eq;
        logic uc_flag;
        assign addr_eq = (mac_vec[g][46:0] == addr_hi);
        assign uc_flag = mac_vec[g][47];
        assign match[g] = addr_eq &&
            (group ? (!uc_flag && (type_vec[g] != KT_CLEAR)) : uc_flag);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = LIDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/kc_key_cache.sv
module kc_key_cache
    import kc_pkg::*;
#(
    parameter int DEPTH      = 128,
    parameter int MIC_OFFSET = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [$clog2(DEPTH)+3:0]   wr_addr,
    input  logic [31:0]                wr_data,
    input  logic                       rd_en,
    input  logic [$clog2(DEPTH)+3:0]   rd_addr,
    output logic [31:0]                rd_data,
    input  logic                       clr_en,
    input  logic [$clog2(DEPTH):0]     clr_idx,
    input  logic                       mic_en,
    input  logic                       lk_valid,
    input  logic [47:0]                lk_addr,
    input  logic                       lk_group,
    output logic                       lk_done,
    output logic                       lk_hit,
    output logic [$clog2(DEPTH)-1:0]   lk_idx,
    output logic [2:0]                 lk_type,
    output logic [127:0]               lk_key,
    output logic                       lk_mic_ok,
    output logic [127:0]               lk_mic
);
    localparam int LIDX_W = $clog2(DEPTH);
    localparam int IDX_W  = LIDX_W + 1;
    localparam int ADDR_W = IDX_W + 3;
    localparam int SLOT_W = LIDX_W + 2;
    localparam int NSLOT  = DEPTH * PAIRS_PER_ENTRY;

    logic [63:0] mem [NSLOT];

    // ---------------- paired write path ----------------
    logic              cm_valid;
    logic [SLOT_W-1:0] cm_slot;
    logic [63:0]       cm_data;

    kc_pair_writer #(.DEPTH(DEPTH)) u_writer (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cm_valid (cm_valid),
        .cm_slot  (cm_slot),
        .cm_data  (cm_data)
    );

    // ---------------- clear path ----------------
    logic              clr_in;
    logic [LIDX_W-1:0] clr_base;
    logic [2:0]        clr_type;
    logic [LIDX_W:0]   clr_mic_sum;
    logic              clr_mic_do;
    logic [LIDX_W-1:0] clr_mic_base;

    assign clr_in       = clr_en && (clr_idx < IDX_W'(DEPTH));
    assign clr_base     = clr_idx[LIDX_W-1:0];
    assign clr_type     = mem[{clr_base, 2'(TYPE_PAIR)}][34:32];
    assign clr_mic_sum  = {1'b0, clr_base} + (LIDX_W+1)'(MIC_OFFSET);
    assign clr_mic_do   = clr_in && mic_en && (clr_type == KT_TKIP) &&
                          (clr_mic_sum < (LIDX_W+1)'(DEPTH));
    assign clr_mic_base = clr_mic_sum[LIDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSLOT; s++) mem[s] <= '0;
        end else begin
            if (cm_valid) mem[cm_slot] <= cm_data;
            if (clr_in) begin
                for (int p = 0; p < PAIRS_PER_ENTRY; p++)
                    mem[{clr_base, 2'(p)}] <= '0;
            end
            if (clr_mic_do) begin
                mem[{clr_mic_base, 2'd0}] <= '0;
                mem[{clr_mic_base, 2'd1}] <= '0;
            end
        end
    end

    // ---------------- register read path ----------------
    logic [IDX_W-1:0]  rd_idx;
    logic [SLOT_W-1:0] rd_slot;
    logic              rd_in;

    assign rd_idx  = rd_addr[ADDR_W-1:3];
    assign rd_slot = rd_addr[SLOT_W:1];
    assign rd_in   = rd_idx < IDX_W'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (!rd_in)          rd_data <= '0;
            else if (rd_addr[0]) rd_data <= mem[rd_slot][63:32];
            else                 rd_data <= mem[rd_slot][31:0];
        end
    end

    // ---------------- lookup path ----------------
    logic [47:0] mac_vec  [DEPTH];
    logic [2:0]  type_vec [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_view
        assign mac_vec[g]  = mem[g*PAIRS_PER_ENTRY + ADDR_PAIR][47:0];
        assign type_vec[g] = mem[g*PAIRS_PER_ENTRY + TYPE_PAIR][34:32];
    end

    logic              sel_hit;
    logic [LIDX_W-1:0] sel_idx;
    logic              unused_addr_lsb;

    assign unused_addr_lsb = lk_addr[0];

    kc_match #(.DEPTH(DEPTH)) u_match (
        .mac_vec  (mac_vec),
        .type_vec (type_vec),
        .addr_hi  (lk_addr[47:1]),
        .group    (lk_group),
        .hit      (sel_hit),
        .idx      (sel_idx)
    );

    logic [2:0]        sel_type;
    logic [127:0]      sel_key;
    logic [LIDX_W:0]   mic_sum;
    logic [LIDX_W-1:0] mic_base;
    logic              mic_ok_c;
    logic [127:0]      mic_key;

    assign sel_type = type_vec[sel_idx];
    assign sel_key  = pack_key(mem[{sel_idx, 2'd0}][47:0],
                               mem[{sel_idx, 2'd1}][47:0],
                               mem[{sel_idx, 2'd2}][31:0],
                               is_short_key(sel_type));
    assign mic_sum  = {1'b0, sel_idx} + (LIDX_W+1)'(MIC_OFFSET);
    assign mic_base = mic_sum[LIDX_W-1:0];
    assign mic_ok_c = sel_hit && mic_en && (sel_type == KT_TKIP) &&
                      (mic_sum < (LIDX_W+1)'(DEPTH));
    assign mic_key  = pack_key(mem[{mic_base, 2'd0}][47:0],
                               mem[{mic_base, 2'd1}][47:0],
                               mem[{mic_base, 2'd2}][31:0],
                               1'b0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_done   <= 1'b0;
            lk_hit    <= 1'b0;
            lk_idx    <= '0;
            lk_type   <= '0;
            lk_key    <= '0;
            lk_mic_ok <= 1'b0;
            lk_mic    <= '0;
        end else begin
            lk_done <= lk_valid;
            if (lk_valid) begin
                lk_hit    <= sel_hit;
                lk_idx    <= sel_hit ? sel_idx : '0;
                lk_type   <= sel_hit ? sel_type : '0;
                lk_key    <= sel_hit ? sel_key : '0;
                lk_mic_ok <= mic_ok_c;
                lk_mic    <= mic_ok_c ? mic_key : '0;
            end
        end
    end

    // ---------------- assertions ----------------
    assert_result_latency_R7: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> lk_done);

    assert_no_spurious_done_R7: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !lk_done);

    assert_miss_is_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (lk_done && !lk_hit) |-> (lk_key == '0 && lk_type == '0 && !lk_mic_ok));

    assert_mic_needs_tkip_R9: assert property (@(posedge clk) disable iff (rst)
        lk_mic_ok |-> (lk_hit && lk_type == KT_TKIP));

    assert_clear_sets_type_R10: assert property (@(posedge clk) disable iff (rst)
        clr_in |=> (mem[{$past(clr_base), 2'(TYPE_PAIR)}][34:32] == KT_CLEAR));

    assert_oor_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_in) |=> (rd_data == '0));

endmodule

// File: tb/kc_key_cache_bench.sv
module kc_key_cache_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [10:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         rd_en = 1'b0;
    logic [10:0]  rd_addr = '0;
    logic [31:0]  rd_data;
    logic         clr_en = 1'b0;
    logic [7:0]   clr_idx = '0;
    logic         mic_en = 1'b0;
    logic         lk_valid = 1'b0;
    logic [47:0]  lk_addr = '0;
    logic         lk_group = 1'b0;
    logic         lk_done, lk_hit, lk_mic_ok;
    logic [6:0]   lk_idx;
    logic [2:0]   lk_type;
    logic [127:0] lk_key, lk_mic;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    kc_key_cache u_kc_key_cache (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .clr_en(clr_en), .clr_idx(clr_idx), .mic_en(mic_en),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_group(lk_group),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .lk_type(lk_type), .lk_key(lk_key),
        .lk_mic_ok(lk_mic_ok), .lk_mic(lk_mic)
    );

    task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] fmask(input int w);
        if (w == 1 || w == 3 || w == 7) return 32'h0000_FFFF;
        if (w == 5) return 32'h0000_0007;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [127:0] kexp(input logic [31:0] k0, k1, k2, k3, k4,
                                          input logic short_key);
        logic [31:0] t;
        t = short_key ? {24'h0, k4[7:0]} : k4;
        return {t, k3[15:0], k2, k1[15:0], k0};
    endfunction

    function automatic logic [31:0] sweep_val(input int i, input int w);
        return 32'h9E37_79B9 * (i * 8 + w + 1);
    endfunction

    task automatic wr(input int idx, input int w, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {idx[7:0], w[2:0]}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int idx, input int w, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = {idx[7:0], w[2:0]};
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic clr(input int idx);
        @(negedge clk);
        clr_en = 1'b1; clr_idx = idx[7:0];
        @(negedge clk);
        clr_en = 1'b0;
    endtask

    task automatic look(input logic [47:0] a, input logic g);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_group = g;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic prog(input int idx, input logic [31:0] k0, k1, k2, k3, k4,
                        input logic [2:0] ty, input logic [47:0] a, input logic flag);
        wr(idx, 0, k0); wr(idx, 1, k1);
        wr(idx, 2, k2); wr(idx, 3, k3);
        wr(idx, 4, k4); wr(idx, 5, {29'h0, ty});
        wr(idx, 6, a[32:1]); wr(idx, 7, {16'h0, flag, a[47:33]});
    endtask

    logic [31:0] d;
    localparam logic [47:0] ADDR_A = 48'h0012_3456_789A;
    localparam logic [47:0] ADDR_B = 48'h00AB_CDEF_0102;
    localparam logic [47:0] ADDR_C = 48'h0055_6677_8898;
    localparam logic [47:0] ADDR_D = 48'h0031_4159_2654;
    localparam logic [47:0] ADDR_G = 48'h0101_5E00_0001;
    localparam logic [47:0] ADDR_H = 48'h0133_3300_0010;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12: reset state
        @(negedge clk);
        chk("R12 lk_hit", {127'h0, lk_hit}, 128'h0);
        chk("R12 lk_key", lk_key, 128'h0);
        chk("R12 rd_data", {96'h0, rd_data}, 128'h0);
        rd(127, 7, d); chk("R12 entry127 w7", {96'h0, d}, 128'h0);
        look(48'h0, 1'b0); chk("R12 lookup miss", {127'h0, lk_hit}, 128'h0);

        // R3: full write sweep then read back masked
        for (int i = 0; i < 128; i++)
            for (int w = 0; w < 8; w++) wr(i, w, sweep_val(i, w));
        for (int i = 0; i < 128; i++)
            for (int w = 0; w < 8; w++) begin
                rd(i, w, d);
                chk($sformatf("R3 e%0d w%0d", i, w), {96'h0, d},
                    {96'h0, sweep_val(i, w) & fmask(w)});
            end

        // R10: clear every entry (mic_en low) and read back zeros
        for (int i = 0; i < 128; i++) clr(i);
        for (int i = 0; i < 128; i++)
            for (int w = 0; w < 8; w++) begin
                rd(i, w, d);
                chk($sformatf("R10 cleared e%0d w%0d", i, w), {96'h0, d}, 128'h0);
            end

        // R1: even alone is invisible, odd commits
        wr(3, 0, 32'hCAFE_0001);
        rd(3, 0, d); chk("R1 even held w0", {96'h0, d}, 128'h0);
        rd(3, 1, d); chk("R1 even held w1", {96'h0, d}, 128'h0);
        wr(3, 1, 32'h1234_BEEF);
        rd(3, 0, d); chk("R1 commit w0", {96'h0, d}, {96'h0, 32'hCAFE_0001});
        rd(3, 1, d); chk("R1 commit w1 masked", {96'h0, d}, {96'h0, 32'h0000_BEEF});

        // R2: interleaved pair drops the held half; lone odd ignored
        wr(4, 0, 32'h1111_1111);
        wr(4, 2, 32'h2222_2222);
        wr(4, 1, 32'h3333_3333);
        rd(4, 0, d); chk("R2 dropped w0", {96'h0, d}, 128'h0);
        rd(4, 1, d); chk("R2 dropped w1", {96'h0, d}, 128'h0);
        wr(5, 3, 32'h4444_4444);
        rd(5, 3, d); chk("R2 lone odd", {96'h0, d}, 128'h0);
        rd(5, 2, d); chk("R2 lone odd w2", {96'h0, d}, 128'h0);

        // R4, R7, R8: unicast lookup with 104-bit key
        prog(10, 32'hA0A1A2A3, 32'h0000B0B1, 32'hC0C1C2C3, 32'h0000D0D1, 32'hE0E1E2E3,
             3'd2, ADDR_A, 1'b1);
        look(ADDR_A, 1'b0);
        chk("R7 done", {127'h0, lk_done}, 128'h1);
        chk("R4 hit", {127'h0, lk_hit}, 128'h1);
        chk("R4 idx", {121'h0, lk_idx}, 128'd10);
        chk("R8 type", {125'h0, lk_type}, 128'd2);
        chk("R8 short key", lk_key,
            kexp(32'hA0A1A2A3, 32'hB0B1, 32'hC0C1C2C3, 32'hD0D1, 32'hE0E1E2E3, 1'b1));
        @(negedge clk);
        chk("R7 done one cycle", {127'h0, lk_done}, 128'h0);
        look(ADDR_A ^ 48'h1, 1'b0);
        chk("R4 bit0 ignored", {127'h0, lk_hit}, 128'h1);
        look(ADDR_A ^ 48'h2, 1'b0);
        chk("R4 bit1 mismatch", {127'h0, lk_hit}, 128'h0);
        look(ADDR_A, 1'b1);
        chk("R5 unicast entry not group", {127'h0, lk_hit}, 128'h0);

        // R5: group lookups with 128-bit key
        prog(20, 32'h01020304, 32'h00000506, 32'h0708090A, 32'h00000B0C, 32'h0D0E0F10,
             3'd3, ADDR_G, 1'b0);
        look(ADDR_G, 1'b1);
        chk("R5 group hit", {127'h0, lk_hit}, 128'h1);
        chk("R5 group idx", {121'h0, lk_idx}, 128'd20);
        chk("R8 full key", lk_key,
            kexp(32'h01020304, 32'h0506, 32'h0708090A, 32'h0B0C, 32'h0D0E0F10, 1'b0));
        look(ADDR_G, 1'b0);
        chk("R4 group entry not unicast", {127'h0, lk_hit}, 128'h0);
        prog(21, 32'h5, 32'h5, 32'h5, 32'h5, 32'h5, 3'd0, ADDR_H, 1'b0);
        look(ADDR_H, 1'b1);
        chk("R5 clear type no group", {127'h0, lk_hit}, 128'h0);

        // R6: lowest index wins, and miss values
        prog(30, 32'h30, 32'h30, 32'h30, 32'h30, 32'h30, 3'd5, ADDR_B, 1'b1);
        prog(12, 32'h12, 32'h12, 32'h12, 32'h12, 32'h12, 3'd6, ADDR_B, 1'b1);
        look(ADDR_B, 1'b0);
        chk("R6 lowest idx", {121'h0, lk_idx}, 128'd12);
        chk("R6 lowest type", {125'h0, lk_type}, 128'd6);
        clr(12);
        look(ADDR_B, 1'b0);
        chk("R6 next idx", {121'h0, lk_idx}, 128'd30);
        look(48'hFFFF_0000_0000, 1'b0);
        chk("R6 miss hit", {127'h0, lk_hit}, 128'h0);
        chk("R6 miss idx", {121'h0, lk_idx}, 128'h0);
        chk("R6 miss key", lk_key, 128'h0);

        // R9: companion integrity key
        prog(5, 32'h55, 32'h55, 32'h55, 32'h55, 32'h55, 3'd4, ADDR_C, 1'b1);
        prog(69, 32'h6901, 32'h00006902, 32'h6903, 32'h00006904, 32'h69056905,
             3'd0, 48'h0, 1'b0);
        mic_en = 1'b1;
        look(ADDR_C, 1'b0);
        chk("R9 mic ok", {127'h0, lk_mic_ok}, 128'h1);
        chk("R9 mic key", lk_mic,
            kexp(32'h6901, 32'h6902, 32'h6903, 32'h6904, 32'h69056905, 1'b0));
        mic_en = 1'b0;
        look(ADDR_C, 1'b0);
        chk("R9 mic off", {127'h0, lk_mic_ok}, 128'h0);
        chk("R9 mic off key", lk_mic, 128'h0);
        mic_en = 1'b1;
        prog(70, 32'h70, 32'h70, 32'h70, 32'h70, 32'h70, 3'd4, ADDR_D, 1'b1);
        look(ADDR_D, 1'b0);
        chk("R9 overflow hit", {127'h0, lk_hit}, 128'h1);
        chk("R9 overflow no mic", {127'h0, lk_mic_ok}, 128'h0);
        look(ADDR_A, 1'b0);
        chk("R9 non-tkip no mic", {127'h0, lk_mic_ok}, 128'h0);

        // R10: clear of a TKIP entry wipes four companion words only
        wr(74, 0, 32'h7474_0000); wr(74, 1, 32'h0000_7474);
        clr(5);
        for (int w = 0; w < 8; w++) begin
            rd(5, w, d); chk($sformatf("R10 e5 w%0d", w), {96'h0, d}, 128'h0);
        end
        for (int w = 0; w < 4; w++) begin
            rd(69, w, d); chk($sformatf("R10 companion w%0d", w), {96'h0, d}, 128'h0);
        end
        rd(69, 4, d); chk("R10 companion KEY4 kept", {96'h0, d}, {96'h0, 32'h69056905});
        look(ADDR_C, 1'b0);
        chk("R10 cleared miss", {127'h0, lk_hit}, 128'h0);
        clr(10);
        rd(74, 0, d); chk("R10 non-tkip companion kept", {96'h0, d}, {96'h0, 32'h7474_0000});
        mic_en = 1'b0;

        // R11: out-of-range indices
        wr(130, 0, 32'hDEAD_0001); wr(130, 1, 32'hDEAD_0002);
        rd(130, 0, d); chk("R11 oor read", {96'h0, d}, 128'h0);
        rd(2, 0, d);   chk("R11 no alias", {96'h0, d}, 128'h0);
        wr(72, 0, 32'h7272_7272); wr(72, 1, 32'h0000_7272);
        clr(200);
        rd(72, 0, d); chk("R11 oor clear ignored", {96'h0, d}, {96'h0, 32'h7272_7272});
        rd(255, 7, d); chk("R11 oor top", {96'h0, d}, 128'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R7 got=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule